// File: doc/BRIEF.md
# NAND Flash Address Cycle Sequencer

This block sits between a flash controller and a small-page NAND device. It takes one request and turns it into the command and address bytes the device expects, together with the latch strobes. A request carries a 24-bit linear address, a flag that selects read or program, and a flag that selects the spare area. The block first sends a pointer command that picks the region of the page. For a program it then sends the serial-data-input command. Three address cycles follow.

The page row is made of bits 23..9: bits 23..14 give the block number and bits 13..9 give the page inside the block. In main-area mode, bits 7..0 are the column. Bit 8 never goes onto the bus; it only chooses the pointer command on an 8-bit bus. The bus may be 8 or 16 bits wide. A 16-bit device has no half-page split, and its spare area is 8 words instead of 16 bytes.

Each bus cycle is a slot of `WE_LO + WE_HI` clocks. Write-enable is low for the first `WE_LO` clocks of a slot. Data and strobes do not change for the whole slot, so they are stable across the rising edge of write-enable. A requester hands over work with a valid/ready handshake. When the sequence ends, the block raises a one-cycle `done` pulse.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, `we_n` is 1, `cle` and `ale` are 0, `io_out` is 0, `req_ready` is 1 and `done` is 0.
- R2: A read request produces 4 slots: the pointer command, then three address cycles. A program request produces 5 slots: the pointer command, command 80h, then the three address cycles. Command slots assert `cle`, and address slots assert `ale`.
- R3: In main-area mode, the first address cycle carries address bits 7..0 on I/O bits 7..0.
- R4: The second address cycle carries address bits 16..9 on I/O bits 7..0.
- R5: The third address cycle carries address bits 23..17 on I/O bits 6..0, with I/O bit 7 driven 0.
- R6: In main-area mode on an 8-bit bus, the pointer command is 00h when address bit 8 is 0 and 01h when it is 1. On a 16-bit bus the pointer command is always 00h. Address bit 8 is never placed on the bus.
- R7: When `req_spare` is 1, the pointer command is 50h and the first address cycle carries the address modulo the spare size in the low bits, with zeros above. The spare size is 16 on an 8-bit bus and 8 on a 16-bit bus.
- R8: `cle` and `ale` are never 1 together. When no request is in progress, both are 0 and `we_n` is 1.
- R9: In every slot, `we_n` is 0 for exactly `WE_LO` clocks and then 1 for `WE_HI` clocks. `io_out`, `cle` and `ale` hold their values through the whole slot.
- R10: On a 16-bit bus, I/O bits 15..8 are 0 in every slot.
- R11: `req_ready` falls in the cycle after a request is accepted and stays 0 until `done`. `done` is a single-cycle pulse in the cycle that follows the last slot, that is `slots*(WE_LO+WE_HI)` cycles after acceptance.
- R12: Holding `req_valid` high while a sequence runs neither restarts it nor changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 24 | Linear flash address |
| req_prog | input | 1 | 1 for program, 0 for read |
| req_spare | input | 1 | 1 to target the spare area |
| io_out | output | BUS_W | Flash I/O bus |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| we_n | output | 1 | Active-low write-enable |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench drives an 8-bit instance and a 16-bit instance with the same stimulus. It compares every clock of every slot against a model. This catches the following faults:
- Sending address bit 8 instead of using it to choose the pointer command shows up as a shifted second or third cycle.
- A third cycle whose top bit is not forced to 0 shows up at the all-ones address.
- Spare requests are run with all-ones low bits. A design that drops the modulo, or uses the wrong spare size for the bus width, then shows a too-large column.
- Program and read requests are mixed. An off-by-one in the slot count or the write-enable timer then moves `done` or cuts the last address cycle short.
- A request is held valid through its whole run. A design that reopened the handshake would restart the sequence.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam logic [7:0] CMD_PTR_FIRST = 8'h00;
  localparam logic [7:0] CMD_PTR_SECOND = 8'h01;
  localparam logic [7:0] CMD_PTR_SPARE = 8'h50;
  localparam logic [7:0] CMD_SERIAL_IN = 8'h80;

  typedef enum logic [1:0] {SK_NONE, SK_CMD, SK_ADDR} slot_kind_e;

  // pointer command: spare area wins, wide bus has no half-page split
  function automatic logic [7:0] pick_pointer(input logic spare, input logic a8,
                                              input logic wide);
    if (spare) return CMD_PTR_SPARE;
    if (wide) return CMD_PTR_FIRST;
    return a8 ? CMD_PTR_SECOND : CMD_PTR_FIRST;
  endfunction

  // column cycle: spare offset wraps at 16 bytes or 8 words
  function automatic logic [7:0] column_cycle(input logic [23:0] a, input logic spare,
                                              input logic wide);
    if (!spare) return a[7:0];
    if (wide) return {5'b0, a[2:0]};
    return {4'b0, a[3:0]};
  endfunction

  function automatic logic [7:0] row_mid_cycle(input logic [23:0] a);
    return a[16:9];
  endfunction

  function automatic logic [7:0] row_top_cycle(input logic [23:0] a);
    return {1'b0, a[23:17]};
  endfunction

endpackage

// File: rtl/nand_seq_slot_map.sv
module nand_seq_slot_map
  import nand_seq_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic [23:0] addr,
  input  logic        prog,
  input  logic        spare,
  input  logic [2:0]  idx,
  output logic [7:0]  cyc_data,
  output slot_kind_e  kind,
  output logic [2:0]  last_idx
);
  localparam logic WIDE = (BUS_W > 8);

  logic [2:0] pos;

  // reads skip the serial-input slot: map onto program numbering
  always_comb begin
    last_idx = prog ? 3'd4 : 3'd3;
    pos = (prog || idx == 3'd0) ? idx : idx + 3'd1;
    cyc_data = 8'h00;
    kind = SK_NONE;
    case (pos)
      3'd0: begin cyc_data = pick_pointer(spare, addr[8], WIDE); kind = SK_CMD; end
      3'd1: begin cyc_data = CMD_SERIAL_IN; kind = SK_CMD; end
      3'd2: begin cyc_data = column_cycle(addr, spare, WIDE); kind = SK_ADDR; end
      3'd3: begin cyc_data = row_mid_cycle(addr); kind = SK_ADDR; end
      3'd4: begin cyc_data = row_top_cycle(addr); kind = SK_ADDR; end
      default: begin cyc_data = 8'h00; kind = SK_NONE; end
    endcase
  end
endmodule

// File: rtl/nand_seq_we_timer.sv
module nand_seq_we_timer #(
  parameter int WE_LO = 2,
  parameter int WE_HI = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic we_low,
  output logic slot_end
);
  localparam int PERIOD = WE_LO + WE_HI;
  localparam int CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
  localparam logic [CW-1:0] LO_V = CW'(WE_LO);
  localparam logic [CW-1:0] LAST_V = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run || cnt == LAST_V) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign we_low = run && (cnt < LO_V);
  assign slot_end = run && (cnt == LAST_V);
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_seq_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int WE_LO = 2,
  parameter int WE_HI = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic             req_prog,
  input  logic             req_spare,
  output logic [BUS_W-1:0] io_out,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             done
);
  logic        busy;
  logic [2:0]  slot;
  logic [23:0] lat_addr;
  logic        lat_prog;
  logic        lat_spare;
  logic        accept;
  logic        we_low;
  logic        slot_end;
  logic        on_last_slot;
  logic [7:0]  cyc_data;
  logic [2:0]  last_idx;
  slot_kind_e  kind;

  assign req_ready = !busy;
  assign accept = req_valid && req_ready;
  assign on_last_slot = busy && (slot == last_idx);

  nand_seq_slot_map #(.BUS_W(BUS_W)) u_map (
    .addr(lat_addr), .prog(lat_prog), .spare(lat_spare), .idx(slot),
    .cyc_data(cyc_data), .kind(kind), .last_idx(last_idx)
  );

  nand_seq_we_timer #(.WE_LO(WE_LO), .WE_HI(WE_HI)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .we_low(we_low), .slot_end(slot_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      slot <= 3'd0;
      lat_addr <= '0;
      lat_prog <= 1'b0;
      lat_spare <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        slot <= 3'd0;
        lat_addr <= req_addr;
        lat_prog <= req_prog;
        lat_spare <= req_spare;
      end else if (slot_end) begin
        if (on_last_slot) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          slot <= slot + 3'd1;
        end
      end
    end
  end

  assign we_n = !we_low;
  assign cle = busy && (kind == SK_CMD);
  assign ale = busy && (kind == SK_ADDR);
  assign io_out = busy ? BUS_W'(cyc_data) : '0;
endmodule

// File: rtl/nand_addr_seq_chk.sv
module nand_addr_seq_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [BUS_W-1:0] io_out,
  input logic             cle,
  input logic             ale,
  input logic             we_n,
  input logic             done,
  input logic             busy,
  input logic             on_last_slot
);
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cle && !ale && we_n));
  a_r5_third_top_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && on_last_slot) |-> !io_out[7]);
  a_r9_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || cle) |-> ((io_out >> 8) == '0));
  a_r11_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r11_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(on_last_slot));
endmodule

bind nand_addr_seq nand_addr_seq_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .io_out(io_out), .cle(cle), .ale(ale), .we_n(we_n), .done(done),
  .busy(busy), .on_last_slot(on_last_slot)
);

// File: tb/nand_addr_seq_test.sv
module nand_addr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WE_LO = 2;
  localparam int WE_HI = 1;
  localparam int PER = WE_LO + WE_HI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_prog = 1'b0;
  logic req_spare = 1'b0;
  logic rdy8, rdy16, cle8, cle16, ale8, ale16, wn8, wn16, dn8, dn16;
  logic [7:0] io8;
  logic [15:0] io16;
  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_addr_seq #(.BUS_W(8), .WE_LO(WE_LO), .WE_HI(WE_HI)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy8),
    .req_addr(req_addr), .req_prog(req_prog), .req_spare(req_spare),
    .io_out(io8), .cle(cle8), .ale(ale8), .we_n(wn8), .done(dn8));

  nand_addr_seq #(.BUS_W(16), .WE_LO(WE_LO), .WE_HI(WE_HI)) uut_w16 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy16),
    .req_addr(req_addr), .req_prog(req_prog), .req_spare(req_spare),
    .io_out(io16), .cle(cle16), .ale(ale16), .we_n(wn16), .done(dn16));

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // bench view of a slot: role 0 ptr, 1 serial-in, 2 column, 3 mid row, 4 top row
  function automatic int role_of(input logic p, input int slot);
    if (p) return slot;
    return (slot == 0) ? 0 : slot + 1;
  endfunction

  function automatic logic [15:0] want_data(input logic [23:0] a, input logic s,
                                            input bit wide, input int role);
    case (role)
      0: return s ? 16'h50 : ((!wide && a[8]) ? 16'h01 : 16'h00);
      1: return 16'h80;
      2: return s ? 16'(a % (wide ? 8 : 16)) : 16'(a & 24'hFF);
      3: return 16'((a >> 9) & 24'hFF);
      default: return 16'((a >> 17) & 24'h7F);
    endcase
  endfunction

  function automatic string tag_of(input logic s, input int role);
    case (role)
      0: return s ? "R7" : "R6";
      1: return "R2";
      2: return s ? "R7" : "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_req(input logic [23:0] a, input logic p, input logic s, input bit hold);
    int n = p ? 5 : 4;
    @(negedge clk);
    req_addr = a; req_prog = p; req_spare = s; req_valid = 1'b1;
    chk(rdy8 === 1'b1 && rdy16 === 1'b1, "R11", "ready before request", {rdy8, rdy16}, 2'b11);
    @(posedge clk);
    for (int c = 0; c <= n * PER; c++) begin
      @(negedge clk);
      if ((!hold && c == 0) || (hold && c == n * PER)) req_valid = 1'b0;
      for (int w = 0; w < 2; w++) begin
        logic wn = w ? wn16 : wn8;
        logic cl = w ? cle16 : cle8;
        logic al = w ? ale16 : ale8;
        logic rd = w ? rdy16 : rdy8;
        logic dn = w ? dn16 : dn8;
        logic [15:0] io = w ? io16 : {8'h00, io8};
        if (c < n * PER) begin
          int role = role_of(p, c / PER);
          logic [15:0] ed = want_data(a, s, w == 1, role);
          bit is_cmd = (role < 2);
          chk(wn === ((c % PER) >= WE_LO), "R9", "we_n", wn, (c % PER) >= WE_LO);
          chk(cl === is_cmd && al === !is_cmd, hold ? "R12" : "R8", "strobes",
              {cl, al}, {is_cmd, !is_cmd});
          if (w == 1) chk(io[15:8] === 8'h00, "R10", "upper byte", io, ed);
          chk(io === ed, hold ? "R12" : tag_of(s, role), "bus data", io, ed);
          chk(rd === 1'b0 && dn === 1'b0, "R11", "ready/done while busy", {rd, dn}, 2'b00);
        end else begin
          chk(dn === 1'b1 && rd === 1'b1, "R11", "done at slot count", {dn, rd}, 2'b11);
          chk(wn === 1'b1 && cl === 1'b0 && al === 1'b0 && io === 16'h0, "R8",
              "quiet after run", {wn, cl, al}, 3'b100);
        end
      end
    end
    @(negedge clk);
    chk(dn8 === 1'b0 && dn16 === 1'b0, "R11", "done single pulse", {dn8, dn16}, 2'b00);
    if (hold) chk(wn8 === 1'b1 && rdy8 === 1'b1 && cle8 === 1'b0, "R12", "no restart",
                  {wn8, rdy8, cle8}, 3'b110);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "WD", "watchdog expired", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(wn8 === 1'b1 && cle8 === 1'b0 && ale8 === 1'b0 && io8 === 8'h0 &&
        rdy8 === 1'b1 && dn8 === 1'b0, "R1", "reset state 8-bit",
        {wn8, cle8, ale8, rdy8, dn8}, 5'b10010);
    chk(wn16 === 1'b1 && io16 === 16'h0 && rdy16 === 1'b1 && dn16 === 1'b0, "R1",
        "reset state 16-bit", {wn16, rdy16, dn16}, 3'b110);
    rst_n = 1'b1;
    // directed corners
    run_req(24'h00_0000, 1'b0, 1'b0, 1'b0);   // R2 R3 zero read
    run_req(24'h12_34FE, 1'b0, 1'b0, 1'b0);   // R6 bit 8 low
    run_req(24'h12_35FE, 1'b0, 1'b0, 1'b0);   // R6 bit 8 high
    run_req(24'hAB_CD5A, 1'b1, 1'b0, 1'b0);   // R2 program with 80h
    run_req(24'hFF_FFFF, 1'b0, 1'b0, 1'b0);   // R5 top bit forced low
    run_req(24'h55_41FF, 1'b0, 1'b1, 1'b0);   // R7 spare modulo
    run_req(24'h3C_C1F7, 1'b1, 1'b1, 1'b0);   // R7 spare program
    run_req(24'h0F_0F0F, 1'b0, 1'b0, 1'b1);   // R12 valid held through run
    run_req(24'hF0_F1F0, 1'b1, 1'b0, 1'b1);   // R12 program held
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r = $urandom;
      run_req(r[23:0], r[24], r[25] & r[26], r[27]);
    end
    finish_run();
  end
endmodule